// File: doc/BRIEF.md
# Lockable Security Control Register

This block holds one 32-bit security control word behind a small word-wide register bus. Beside it sit a sticky lock register and a key register. Each lock bit guards a fixed group of control fields. Once a lock bit is set, that group keeps its value on every later control write, and only a reset can clear the lock bit again.

The key register controls the whole register window. When the fixed key is written, the partial-reconfiguration enable and the three encryption-enable bits are forced on. Any other value forces them off and closes the window: reads return zero and writes are dropped until the next reset.

The control word goes out in parallel. A warning flag is raised while the 3-bit encryption-enable field holds a mixed value. Accesses are always full 32-bit words and take effect on the clock edge that samples them. Reads are combinational.

Top module: `sec_ctrl_reg`

## Requirements
- R1: After reset the control word is 0x0C006000, the lock register reads 0, the window is open and the warning flag is low.
- R2: A lock write ORs data bits 4:0 into the lock register, so a set lock bit cannot be cleared by writes. Lock bits 31:5 read as zero.
- R3: In a control write, all unlocked writable bits take the written data. Bit 31 is a reset request: writes to it are ignored and it reads 0. Reserved bits 28 and 22:13 keep their reset value (bits 14:13 read 1, the others 0).
- R4: The lock groups are: lock bit 0 covers control bits 6:0, bit 1 covers bit 7, bit 2 covers bit 8, bit 3 covers bits 11:9, and bit 4 covers bit 12. While a lock bit is set, a control write leaves its group unchanged. No other control bit can be locked.
- R5: Writing 0x757BDF0D to the key register sets control bits 27 and 11:9, even when they are locked, and the window stays open.
- R6: Writing any other value to the key register clears control bits 27 and 11:9 and closes the window.
- R7: While the window is closed, every read returns 0 and every write (control, lock or key) is dropped until the next reset.
- R8: The warning flag is high exactly when control bits 11:9 are neither 000 nor 111.
- R9: The bus word addresses are: 0 for control, 1 for lock, 2 for key. A read of the key address or of address 3 returns 0, and a write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| access_en_o | output | 1 | Register window open |
| ctrl_o | output | 32 | Current control word |
| enc_warn_o | output | 1 | Encryption-enable field inconsistent |

## Verification
The hardest situations to reach are the ones where locks and the key interact. One is a key write landing on a locked encryption field. The other is a closed window that has to reject a later correct key. The stimulus first sets every lock bit and hammers the control word with all-ones and all-zeros patterns. It then writes the correct key over the locked field, and then a wrong key. After the wrong key it tries control, lock and key writes and reads at every address. A second reset then shows that only reset reopens the window.

// File: rtl/sec_ctrl_pkg.sv
package sec_ctrl_pkg;
  localparam int DW       = 32;
  localparam int AW       = 2;
  localparam int NUM_LOCK = 5;
  localparam logic [DW-1:0] UNLOCK_KEY = 32'h757B_DF0D;
  localparam logic [DW-1:0] CTRL_RST   = 32'h0C00_6000;
  // bit 31 request, bit 28 and 22:13 reserved
  localparam logic [DW-1:0] CTRL_WMASK = ~(32'h8000_0000 | 32'h1000_0000 | 32'h007F_E000);
  localparam logic [DW-1:0] KEY_FORCE  = 32'h0800_0E00;
  localparam int ENC_LO = 9;
  localparam int ENC_W  = 3;

  typedef enum logic [AW-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LOCK = 2'd1,
    ADDR_KEY  = 2'd2
  } reg_addr_e;

  function automatic logic [DW-1:0] group_mask(input int idx);
    case (idx)
      0:       group_mask = 32'h0000_007F;
      1:       group_mask = 32'h0000_0080;
      2:       group_mask = 32'h0000_0100;
      3:       group_mask = 32'h0000_0E00;
      4:       group_mask = 32'h0000_1000;
      default: group_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/sec_lock_reg.sv
module sec_lock_reg #(
  parameter int NUM_LOCK = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [NUM_LOCK-1:0] wdata_i,
  output logic [NUM_LOCK-1:0] lock_o
);
  logic [NUM_LOCK-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lock_q <= '0;
    else if (wr_i) lock_q <= lock_q | wdata_i;
  end

  assign lock_o = lock_q;

  assert_lock_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q & $past(lock_q)) == $past(lock_q));
endmodule

// File: rtl/sec_key_gate.sv
module sec_key_gate #(
  parameter int            DW  = 32,
  parameter logic [DW-1:0] KEY = 32'h757B_DF0D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          en_o,
  output logic          good_o,
  output logic          bad_o
);
  logic en_q;
  logic match;

  assign match  = (wdata_i == KEY);
  assign good_o = wr_i && match;
  assign bad_o  = wr_i && !match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= 1'b1;
    else if (bad_o) en_q <= 1'b0;
  end

  assign en_o = en_q;

  assert_stays_closed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !en_q);
endmodule

// File: rtl/sec_ctrl_core.sv
module sec_ctrl_core
  import sec_ctrl_pkg::*;
#(
  parameter int NLOCK = NUM_LOCK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NLOCK-1:0] lock_i,
  input  logic             good_i,
  input  logic             bad_i,
  output logic [DW-1:0]    ctrl_o
);
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] hold, take;
  logic [DW-1:0] grp_hold [NLOCK];

  for (genvar g = 0; g < NLOCK; g++) begin : g_grp
    assign grp_hold[g] = lock_i[g] ? group_mask(g) : '0;

    assert_group_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(lock_i[g]) && !$past(good_i) && !$past(bad_i)) |->
      ((ctrl_q & group_mask(g)) == ($past(ctrl_q) & group_mask(g))));
  end

  always_comb begin
    hold = '0;
    for (int i = 0; i < NLOCK; i++) hold = hold | grp_hold[i];
  end

  assign take = CTRL_WMASK & ~hold;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i)        ctrl_d = (wdata_i & take) | (ctrl_q & ~take);
    else if (good_i) ctrl_d = ctrl_q | KEY_FORCE;
    else if (bad_i)  ctrl_d = ctrl_q & ~KEY_FORCE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  assert_reserved_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[31] && !ctrl_q[28] && (ctrl_q[22:13] == 10'h003));
endmodule

// File: rtl/sec_ctrl_reg.sv
module sec_ctrl_reg
  import sec_ctrl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          access_en_o,
  output logic [DW-1:0] ctrl_o,
  output logic          enc_warn_o
);
  logic                en;
  logic                wr_ok;
  logic                ctrl_wr, lock_wr, key_wr;
  logic                key_good, key_bad;
  logic [NUM_LOCK-1:0] lock;
  logic [DW-1:0]       ctrl;
  logic [ENC_W-1:0]    enc;

  assign wr_ok   = req_i && we_i && en;
  assign ctrl_wr = wr_ok && (addr_i == ADDR_CTRL);
  assign lock_wr = wr_ok && (addr_i == ADDR_LOCK);
  assign key_wr  = wr_ok && (addr_i == ADDR_KEY);

  sec_lock_reg #(.NUM_LOCK(NUM_LOCK)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (lock_wr),
    .wdata_i(wdata_i[NUM_LOCK-1:0]),
    .lock_o (lock)
  );

  sec_key_gate #(.DW(DW), .KEY(UNLOCK_KEY)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (key_wr),
    .wdata_i(wdata_i),
    .en_o   (en),
    .good_o (key_good),
    .bad_o  (key_bad)
  );

  sec_ctrl_core #(.NLOCK(NUM_LOCK)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctrl_wr),
    .wdata_i(wdata_i),
    .lock_i (lock),
    .good_i (key_good),
    .bad_i  (key_bad),
    .ctrl_o (ctrl)
  );

  always_comb begin
    rdata_o = '0;
    if (en) begin
      case (addr_i)
        ADDR_CTRL: rdata_o = ctrl;
        ADDR_LOCK: rdata_o = {{(DW-NUM_LOCK){1'b0}}, lock};
        default:   rdata_o = '0;
      endcase
    end
  end

  assign enc         = ctrl[ENC_LO +: ENC_W];
  assign enc_warn_o  = (enc != '0) && (enc != '1);
  assign access_en_o = en;
  assign ctrl_o      = ctrl;

  assert_key_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(key_good) |-> (ctrl[27] && (enc == 3'b111) && en));

  assert_bad_key_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(key_bad) |-> (!ctrl[27] && (enc == 3'b000) && !en));

  assert_closed_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en) |-> (ctrl == $past(ctrl)));

  assert_no_warn_after_key_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(key_good) |-> !enc_warn_o);
endmodule

// File: tb/tb_sec_ctrl_reg.sv
module tb_sec_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, ctrl_o;
  logic        access_en, warn;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_ctrl;
  logic [4:0]  m_lock;
  bit          m_en;

  always #10 clk = ~clk;

  sec_ctrl_reg dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .access_en_o(access_en),
    .ctrl_o(ctrl_o), .enc_warn_o(warn)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [1:0] a);
    if (!m_en) return 32'h0;
    if (a == 2'd0) return m_ctrl;
    if (a == 2'd1) return {27'h0, m_lock};
    return 32'h0;
  endfunction

  function automatic bit m_warn();
    logic [2:0] f = m_ctrl[11:9];
    return (f != 3'b000) && (f != 3'b111);
  endfunction

  task automatic m_apply(bit w, logic [1:0] a, logic [31:0] d);
    logic [31:0] wm, gm, nv;
    if (!(w && m_en)) return;
    if (a == 2'd0) begin
      wm = 32'h6F80_1FFF;
      nv = (d & wm) | (m_ctrl & ~wm);
      for (int i = 0; i < 5; i++) begin
        gm = (i == 0) ? 32'h7F : (i == 1) ? 32'h80 : (i == 2) ? 32'h100 :
             (i == 3) ? 32'hE00 : 32'h1000;
        if (m_lock[i]) nv = (nv & ~gm) | (m_ctrl & gm);
      end
      m_ctrl = nv;
    end else if (a == 2'd1) begin
      m_lock = m_lock | d[4:0];
    end else if (a == 2'd2) begin
      if (d == 32'h757B_DF0D) m_ctrl = m_ctrl | 32'h0800_0E00;
      else begin
        m_ctrl = m_ctrl & ~32'h0800_0E00;
        m_en = 0;
      end
    end
  endtask

  task automatic compare(string tag);
    check({tag, " ctrl"}, ctrl_o, m_ctrl);
    check({tag, " en"}, {31'h0, access_en}, {31'h0, m_en});
    check({tag, " R8 warn"}, {31'h0, warn}, {31'h0, m_warn()});
  endtask

  // one bus cycle, driven and checked at the falling edge
  task automatic op(bit w, logic [1:0] a, logic [31:0] d, string tag);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    if (!w) check({tag, " rdata"}, rdata, m_read(a));
    @(posedge clk);
    m_apply(w, a, d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    m_ctrl = 32'h0C00_6000; m_lock = '0; m_en = 1;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    op(0, 2'd0, 0, "R1");
    op(0, 2'd1, 0, "R1");
    // R3 plain writes, bit 31 ignored, reserved held
    op(1, 2'd0, 32'hFFFF_FFFF, "R3");
    op(0, 2'd0, 0, "R3");
    op(1, 2'd0, 32'h0000_0000, "R3");
    op(1, 2'd0, 32'hA5A5_5A5A, "R3");
    // R8 warning patterns
    op(1, 2'd0, 32'h0000_0200, "R8");
    op(1, 2'd0, 32'h0000_0C00, "R8");
    op(1, 2'd0, 32'h0000_0E00, "R8");
    op(1, 2'd0, 32'h0000_0000, "R8");
    // R9 unused address
    op(1, 2'd3, 32'hFFFF_FFFF, "R9");
    op(0, 2'd3, 0, "R9");
    op(0, 2'd2, 0, "R9");
    // R4 debug group lock
    op(1, 2'd1, 32'h0000_0001, "R4");
    op(1, 2'd0, 32'hFFFF_FFFF, "R4");
    op(0, 2'd0, 0, "R4");
    // R2 sticky, reserved lock bits
    op(1, 2'd1, 32'hFFFF_FFE0, "R2");
    op(0, 2'd1, 0, "R2");
    op(1, 2'd1, 32'h0000_0000, "R2");
    op(0, 2'd1, 0, "R2");
    op(1, 2'd1, 32'h0000_0008, "R4");
    op(1, 2'd0, 32'h0000_0000, "R4");
    op(1, 2'd1, 32'h0000_0016, "R4");
    op(1, 2'd0, 32'h0000_0000, "R4");
    op(1, 2'd0, 32'hFFFF_FFFF, "R4");
    op(0, 2'd1, 0, "R2");
    // R5 key over locked field
    op(1, 2'd2, 32'h757B_DF0D, "R5");
    op(0, 2'd0, 0, "R5");
    do_reset();
    op(1, 2'd0, 32'h0000_0A00, "R8");
    op(1, 2'd2, 32'h757B_DF0D, "R5");
    // R6 wrong key
    op(1, 2'd2, 32'h757B_DF0C, "R6");
    // R7 closed window
    op(0, 2'd0, 0, "R7");
    op(0, 2'd1, 0, "R7");
    op(1, 2'd0, 32'hFFFF_FFFF, "R7");
    op(1, 2'd1, 32'h0000_001F, "R7");
    op(1, 2'd2, 32'h757B_DF0D, "R7");
    op(0, 2'd0, 0, "R7");
    do_reset();
    op(0, 2'd0, 0, "R1");
    op(0, 2'd1, 0, "R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule